// File: doc/BRIEF.md
# Masked device interrupt router

The block collects up to 64 device interrupt sources and steers them to as many as four processors. Each source has a raise pulse and a clear pulse. The block keeps a raw request vector with one bit per source. Each processor has its own 64-bit enable mask. A processor's pending vector is its mask ANDed with the raw vector. Each processor gets one level-sensitive interrupt line, which is high while its pending vector holds any bit.

Software uses a small 64-bit register port to program the masks and to read back the pending vectors and the raw vector. The register index is the byte address shifted right by six. A run-time processor count chooses which processors track source activity. Processors at or above the count keep the pending vector they had, until their own mask is written again. An illegal access returns an error response, changes no state and sets a sticky error flag.

Top module: `dev_irq_router`

## Requirements
- R1: Reset clears the raw vector, every mask, every pending vector, all interrupt lines, the response outputs and the sticky error flag.
- R2: A raise pulse on source n sets raw bit n. In the same edge it sets pending bit n for every counted processor whose mask bit n is 1.
- R3: A legal mask write sets that processor's pending vector to the new mask ANDed with the raw vector. This happens whatever the processor count is.
- R4: A clear pulse on a source whose raw bit is set clears that raw bit and clears the bit in every counted processor's pending vector.
- R5: A clear pulse on a source whose raw bit is already clear changes no raw bit, no pending bit and no interrupt line.
- R6: When raise and clear pulses hit the same source in the same cycle, the raise wins and the raw bit ends up set.
- R7: The register index is the byte address divided by 64, and the byte address must be a multiple of 64. Index 0 to 3 are the processor masks (read/write). Index 4 to 7 are the pending vectors (read-only). Index 8 is the raw vector (read-only). Every request gets a response one cycle later, carrying the read data.
- R8: The size code 3 means a full 64-bit access. Any other size code gives an error response and writes nothing.
- R9: The following give an error response with zero data and change no state: a write to a read-only index, an access to an unimplemented index, and an address that is not a multiple of 64. Any error response sets the sticky error flag, which stays set until reset.
- R10: A source change updates the pending vector only for processors whose number is below the cpu_cnt input (0 to 4). The other processors keep their pending vectors.
- R11: Each interrupt line is the OR of its processor's pending vector. It changes on the same clock edge as the pending register, one cycle after the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_cnt | input | 3 | Number of processors that follow source changes |
| src_set | input | 64 | Raise pulses, one bit per source |
| src_clr | input | 64 | Clear pulses, one bit per source |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address of the register |
| req_size | input | 2 | Access size code; 3 = 64-bit |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | The request was rejected |
| rsp_rdata | output | 64 | Read data; zero on writes and errors |
| err_sticky | output | 1 | Set by any rejected request until reset |
| cpu_irq | output | 4 | Interrupt level for each processor |

## Verification
The bench targets the following corner cases:
- A spurious clear. A design that did not ignore it would drop pending bits or lines that belong to other sources.
- Simultaneous raise and clear of one source. Clear priority would lose the request.
- A processor count below four. A design that ignored the count would update inactive processors' pending vectors. A design that also gated mask writes by the count would leave a freshly written mask without its pending bits.
- Illegal accesses: short sizes, writes to read-only indices, unaligned and unmapped addresses. Each must be refused with no state change, and the error flag must remain set afterwards.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int CNT_W         = 3;
    localparam int CPU_W         = 2;
    localparam int IDX_MASK_BASE = 0;
    localparam int IDX_PEND_BASE = 4;
    localparam int IDX_RAW       = 8;
    localparam int LOW_BITS      = 6;

    localparam logic [1:0] SIZE_FULL = 2'd3;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_MASK = 2'd1,
        RD_PEND = 2'd2,
        RD_RAW  = 2'd3
    } rd_kind_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_route_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NCPU   = 4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic [NCPU-1:0]   mask_we,
    output rd_kind_e          rd_kind,
    output logic [CPU_W-1:0]  rd_cpu,
    output logic              bad
);

    localparam int IDX_W = ADDR_W - LOW_BITS;

    logic [IDX_W-1:0]    idx;
    logic [LOW_BITS-1:0] low;
    logic                hit;

    assign idx = req_addr[ADDR_W-1:LOW_BITS];
    assign low = req_addr[LOW_BITS-1:0];

    always_comb begin
        mask_we = '0;
        rd_kind = RD_NONE;
        rd_cpu  = '0;
        bad     = 1'b0;
        hit     = 1'b0;
        if (req_valid) begin
            if (req_size != SIZE_FULL || low != '0) begin
                bad = 1'b1;
            end else begin
                for (int c = 0; c < NCPU; c++) begin
                    if (idx == IDX_W'(IDX_MASK_BASE + c)) begin
                        hit = 1'b1;
                        if (req_write) begin
                            mask_we[c] = 1'b1;
                        end else begin
                            rd_kind = RD_MASK;
                            rd_cpu  = CPU_W'(c);
                        end
                    end
                    if (idx == IDX_W'(IDX_PEND_BASE + c)) begin
                        hit = 1'b1;
                        if (req_write) begin
                            bad = 1'b1;
                        end else begin
                            rd_kind = RD_PEND;
                            rd_cpu  = CPU_W'(c);
                        end
                    end
                end
                if (idx == IDX_W'(IDX_RAW)) begin
                    hit = 1'b1;
                    if (req_write) bad = 1'b1;
                    else           rd_kind = RD_RAW;
                end
                if (!hit) bad = 1'b1;
            end
        end
    end

    always_comb begin
        assert (!(bad && (mask_we != '0))) else $error("AST_BAD_NO_WE failed"); // R9
        assert ($onehot0(mask_we)) else $error("AST_WE_ONEHOT failed"); // R7
    end

endmodule

// File: rtl/irq_raw_vec.sv
module irq_raw_vec #(
    parameter int NSRC = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_set,
    input  logic [NSRC-1:0] src_clr,
    output logic [NSRC-1:0] raw_q,
    output logic [NSRC-1:0] raw_nx,
    output logic            raw_chg
);

    typedef struct packed {
        logic [NSRC-1:0] raw;
    } raw_st_t;

    raw_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.raw = (st_q.raw & ~src_clr) | src_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_q   = st_q.raw;
    assign raw_nx  = st_d.raw;
    assign raw_chg = (st_d.raw != st_q.raw);

    AST_SPURIOUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set == '0 && (src_clr & raw_q) == '0) |=> $stable(raw_q)) else $error("AST_SPURIOUS_CLR"); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((raw_q & $past(src_set)) == $past(src_set))) else $error("AST_SET_WINS"); // R6
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_clr & ~src_set) != '0) |=> ((raw_q & $past(src_clr & ~src_set)) == '0)) else $error("AST_CLR_DROPS"); // R4

endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice
    import irq_route_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int CPU_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cpu_cnt,
    input  logic             mask_we,
    input  logic [NSRC-1:0]  wdata,
    input  logic [NSRC-1:0]  raw_q,
    input  logic [NSRC-1:0]  raw_nx,
    input  logic             raw_chg,
    output logic [NSRC-1:0]  mask_q,
    output logic [NSRC-1:0]  pend_q,
    output logic             irq_q
);

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] pend;
        logic            irq;
    } slice_st_t;

    slice_st_t st_d, st_q;
    logic      active;

    assign active = (cpu_cnt > CNT_W'(CPU_ID));

    always_comb begin
        st_d = st_q;
        if (mask_we) st_d.mask = wdata;
        if (mask_we || (active && raw_chg)) st_d.pend = st_d.mask & raw_nx;
        st_d.irq = |st_d.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q = st_q.mask;
    assign pend_q = st_q.pend;
    assign irq_q  = st_q.irq;

    AST_MASK_WR_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (pend_q == (mask_q & raw_q))) else $error("AST_MASK_WR_PEND"); // R3
    AST_ACTIVE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (active && raw_chg) |=> (pend_q == (mask_q & raw_q))) else $error("AST_ACTIVE_TRACK"); // R2
    AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !mask_we) |=> $stable(pend_q)) else $error("AST_INACTIVE_HOLD"); // R10
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q)) else $error("AST_MASK_HOLD"); // R9
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (|pend_q)) else $error("AST_IRQ_LEVEL"); // R11

endmodule

// File: rtl/dev_irq_router.sv
module dev_irq_router
    import irq_route_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int NCPU   = 4,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cpu_cnt,
    input  logic [NSRC-1:0]   src_set,
    input  logic [NSRC-1:0]   src_clr,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [NSRC-1:0]   req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [NSRC-1:0]   rsp_rdata,
    output logic              err_sticky,
    output logic [NCPU-1:0]   cpu_irq
);

    typedef struct packed {
        logic            rsp_valid;
        logic            rsp_err;
        logic [NSRC-1:0] rsp_rdata;
        logic            err;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NCPU-1:0]  mask_we;
    rd_kind_e         rd_kind;
    logic [CPU_W-1:0] rd_cpu;
    logic             bad;
    logic [NSRC-1:0]  raw_q, raw_nx;
    logic             raw_chg;
    logic [NSRC-1:0]  mask_all [NCPU];
    logic [NSRC-1:0]  pend_all [NCPU];
    logic [NSRC-1:0]  rd_mux;

    irq_reg_decode #(.ADDR_W(ADDR_W), .NCPU(NCPU)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .mask_we   (mask_we),
        .rd_kind   (rd_kind),
        .rd_cpu    (rd_cpu),
        .bad       (bad)
    );

    irq_raw_vec #(.NSRC(NSRC)) u_raw (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_set (src_set),
        .src_clr (src_clr),
        .raw_q   (raw_q),
        .raw_nx  (raw_nx),
        .raw_chg (raw_chg)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        irq_cpu_slice #(.NSRC(NSRC), .CPU_ID(c)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .cpu_cnt (cpu_cnt),
            .mask_we (mask_we[c]),
            .wdata   (req_wdata),
            .raw_q   (raw_q),
            .raw_nx  (raw_nx),
            .raw_chg (raw_chg),
            .mask_q  (mask_all[c]),
            .pend_q  (pend_all[c]),
            .irq_q   (cpu_irq[c])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (rd_cpu == CPU_W'(c)) begin
                if (rd_kind == RD_MASK) rd_mux = mask_all[c];
                if (rd_kind == RD_PEND) rd_mux = pend_all[c];
            end
        end
        if (rd_kind == RD_RAW) rd_mux = raw_q;
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_err   = req_valid && bad;
        st_d.rsp_rdata = (req_valid && !bad && !req_write) ? rd_mux : '0;
        st_d.err       = st_q.err || (req_valid && bad);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_err    = st_q.rsp_err;
    assign rsp_rdata  = st_q.rsp_rdata;
    assign err_sticky = st_q.err;

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid) else $error("AST_RSP_NEXT"); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky) else $error("AST_ERR_STICKY"); // R9
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0)) else $error("AST_ERR_ZERO_DATA"); // R9
    AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> err_sticky) else $error("AST_ERR_FLAGGED"); // R9

endmodule

// File: tb/dev_irq_router_bench.sv
`timescale 1ns/1ps
module dev_irq_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cpu_cnt = 3'd4;
    logic [63:0] src_set = '0, src_clr = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [1:0]  req_size = 2'd3;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, err_sticky;
    logic [63:0] rsp_rdata;
    logic [3:0]  cpu_irq;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dev_irq_router u_dev_irq_router (
        .clk(clk), .rst_n(rst_n), .cpu_cnt(cpu_cnt),
        .src_set(src_set), .src_clr(src_clr),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .err_sticky(err_sticky), .cpu_irq(cpu_irq)
    );

    // kind: 0 raise, 1 clear, 2 write, 3 read; exp_irq checked always, exp_data on reads
    localparam int NV = 12;
    localparam logic [143:0] TBL [NV] = '{
        {2'd2, 10'h000, 64'h0000_0000_0000_00F0, 4'b0000, 64'h0},
        {2'd2, 10'h040, 64'h8000_0000_0000_0010, 4'b0000, 64'h0},
        {2'd0, 10'h000, 64'h0000_0000_0000_0010, 4'b0011, 64'h0},
        {2'd3, 10'h100, 64'h0,                   4'b0011, 64'h0000_0000_0000_0010},
        {2'd0, 10'h000, 64'h8000_0000_0000_0000, 4'b0011, 64'h0},
        {2'd3, 10'h200, 64'h0,                   4'b0011, 64'h8000_0000_0000_0010},
        {2'd1, 10'h000, 64'h0000_0000_0000_0010, 4'b0010, 64'h0},
        {2'd3, 10'h140, 64'h0,                   4'b0010, 64'h8000_0000_0000_0000},
        {2'd2, 10'h080, 64'hFFFF_FFFF_FFFF_FFFF, 4'b0110, 64'h0},
        {2'd2, 10'h040, 64'h0,                   4'b0100, 64'h0},
        {2'd3, 10'h080, 64'h0,                   4'b0100, 64'hFFFF_FFFF_FFFF_FFFF},
        {2'd1, 10'h000, 64'h8000_0000_0000_0000, 4'b0000, 64'h0}
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic src_op(input logic [63:0] s, input logic [63:0] c);
        @(negedge clk);
        src_set = s;
        src_clr = c;
        @(negedge clk);
        src_set = '0;
        src_clr = '0;
    endtask

    task automatic reg_op(input logic w, input logic [9:0] a, input logic [1:0] sz,
                          input logic [63:0] d, output logic [63:0] rd, output logic e);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_size  = sz;
        req_wdata = d;
        @(negedge clk);
        rd = rsp_rdata;
        e  = rsp_err;
        chk("R7 rsp_valid one cycle after request", 64'(rsp_valid), 64'd1);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_size  = 2'd3;
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] rd;
        logic        e;
        logic [143:0] ent;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq after reset", 64'(cpu_irq), 64'h0);
        chk("R1 err_sticky after reset", 64'(err_sticky), 64'h0);
        chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'h0);
        reg_op(1'b0, 10'h200, 2'd3, '0, rd, e);
        chk("R1 raw after reset", rd, 64'h0);
        reg_op(1'b0, 10'h0C0, 2'd3, '0, rd, e);
        chk("R1 mask3 after reset", rd, 64'h0);
        chk("R7 legal read no error", 64'(e), 64'h0);

        // table walk: R2 R3 R4 R7 R11
        for (int i = 0; i < NV; i++) begin
            ent = TBL[i];
            case (ent[143:142])
                2'd0: src_op(ent[131:68], 64'h0);
                2'd1: src_op(64'h0, ent[131:68]);
                2'd2: reg_op(1'b1, ent[141:132], 2'd3, ent[131:68], rd, e);
                default: begin
                    reg_op(1'b0, ent[141:132], 2'd3, 64'h0, rd, e);
                    chk($sformatf("R7 table read %0d data", i), rd, ent[63:0]);
                end
            endcase
            chk($sformatf("R2 R3 R4 R11 table step %0d irq", i), 64'(cpu_irq), 64'(ent[67:64]));
        end

        // R5 spurious clear
        src_op(64'h80, 64'h0);
        chk("R2 raise bit7 irq", 64'(cpu_irq), 64'b0101);
        src_op(64'h0, 64'h100);
        chk("R5 spurious clear irq", 64'(cpu_irq), 64'b0101);
        reg_op(1'b0, 10'h200, 2'd3, '0, rd, e);
        chk("R5 spurious clear raw", rd, 64'h80);
        reg_op(1'b0, 10'h100, 2'd3, '0, rd, e);
        chk("R5 spurious clear pend0", rd, 64'h80);

        // R6 raise and clear together
        src_op(64'h200, 64'h200);
        reg_op(1'b0, 10'h200, 2'd3, '0, rd, e);
        chk("R6 set wins raw", rd, 64'h280);

        // R10 processor count
        @(negedge clk);
        cpu_cnt = 3'd2;
        reg_op(1'b1, 10'h0C0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, rd, e);
        chk("R3 mask write on inactive cpu irq", 64'(cpu_irq), 64'b1101);
        src_op(64'h2, 64'h0);
        reg_op(1'b0, 10'h180, 2'd3, '0, rd, e);
        chk("R10 inactive pend2 holds", rd, 64'h280);
        reg_op(1'b0, 10'h1C0, 2'd3, '0, rd, e);
        chk("R3 pend3 from mask write", rd, 64'h280);
        src_op(64'h0, 64'h80);
        chk("R10 active cpu0 drops, inactive keep", 64'(cpu_irq), 64'b1100);
        reg_op(1'b0, 10'h180, 2'd3, '0, rd, e);
        chk("R10 pend2 stale after clear", rd, 64'h280);
        @(negedge clk);
        cpu_cnt = 3'd4;
        src_op(64'h0, 64'h200);
        reg_op(1'b0, 10'h1C0, 2'd3, '0, rd, e);
        chk("R4 pend3 recomputed", rd, 64'h2);
        chk("R11 irq after recompute", 64'(cpu_irq), 64'b1100);

        // R8 short access
        reg_op(1'b1, 10'h000, 2'd2, 64'h0, rd, e);
        chk("R8 short write error", 64'(e), 64'h1);
        chk("R8 err_sticky set", 64'(err_sticky), 64'h1);
        reg_op(1'b0, 10'h000, 2'd3, '0, rd, e);
        chk("R8 mask0 unchanged", rd, 64'hF0);
        chk("R9 legal read after error no err", 64'(e), 64'h0);

        // R9 illegal targets
        reg_op(1'b1, 10'h200, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, rd, e);
        chk("R9 write raw error", 64'(e), 64'h1);
        reg_op(1'b1, 10'h100, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, rd, e);
        chk("R9 write pend error", 64'(e), 64'h1);
        reg_op(1'b0, 10'h200, 2'd3, '0, rd, e);
        chk("R9 raw unchanged", rd, 64'h2);
        reg_op(1'b0, 10'h100, 2'd3, '0, rd, e);
        chk("R9 pend0 unchanged", rd, 64'h0);
        reg_op(1'b0, 10'h240, 2'd3, '0, rd, e);
        chk("R9 unmapped read error", 64'(e), 64'h1);
        chk("R9 unmapped read data zero", rd, 64'h0);
        reg_op(1'b0, 10'h088, 2'd3, '0, rd, e);
        chk("R9 unaligned read error", 64'(e), 64'h1);
        chk("R9 err_sticky stays", 64'(err_sticky), 64'h1);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after second reset", 64'(cpu_irq), 64'h0);
        chk("R1 err_sticky after second reset", 64'(err_sticky), 64'h0);
        reg_op(1'b0, 10'h080, 2'd3, '0, rd, e);
        chk("R1 mask2 after second reset", rd, 64'h0);

        finish_run();
    end

endmodule